// File: doc/BRIEF.md
# LCD Controller Power-Up Sequencer

This block brings a display controller on a byte-serial link out of reset and into a running state. A `start` pulse first drives the panel's active-low hardware reset pin low for one millisecond, then releases it and waits another millisecond. It then plays a built-in table of configuration records to a byte-wide transmit handshake, one byte per accepted transfer. The `tx_dc` flag marks each byte as an opcode (0) or a parameter (1).

Each table record holds a parameter count, then the opcode, then that many parameter bytes. The count itself is never transmitted. After the last record the block waits five milliseconds and then sends the display-on opcode. `done` rises once that opcode has been accepted.

While no sequence is running, a power request sends a single-opcode record: enter sleep or leave sleep. The serializer that shifts the bytes out is a separate block.

Top module: `lcd_bringup_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `lcd_rst_n` is 1, `tx_valid` is 0 and `done` is 0 until a request arrives.
- R2: A `start` seen while idle drives `lcd_rst_n` low for exactly `MS_TICKS` clock cycles. `lcd_rst_n` then stays high for at least `MS_TICKS` cycles before the first byte is offered, and no byte is offered while it is low.
- R3: Each table record is a count byte N (0 to 15), then an opcode, then N parameter bytes. The count byte is not sent. The opcode goes out with `tx_dc`=0 and every parameter with `tx_dc`=1, so a count of 0 sends the opcode alone.
- R4: The table sends these records, as hex opcode:parameters, in this order:
  - C0:26
  - 36:28
  - 3A:55
  - E0:0F 31 2B 0C 0E 08 4E F1 37 07 10 03 0E 09 00
  - E1:00 0E 14 03 11 07 31 C1 48 08 0F 0C 31 36 0F
  - 11 with no parameters
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_dc` hold their values. A byte advances only on a cycle with both high, and each table byte is sent exactly once.
- R6: At least 5*`MS_TICKS` cycles after the last table byte is accepted, the block offers opcode 0x29 with `tx_dc`=0.
- R7: `done` rises in the cycle after 0x29 is accepted. It stays high until the next accepted `start`, which clears it.
- R8: A `start` that arrives while a sequence is running is ignored. It produces no second reset pulse and does not change the byte stream.
- R9: A `pwr_req` seen while idle sends one byte with `tx_dc`=0: 0x10 when `pwr_on` is 0 and 0x11 when it is 1. It leaves `done` and `lcd_rst_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the full bring-up sequence |
| pwr_req | input | 1 | Request a single sleep-control opcode |
| pwr_on | input | 1 | With `pwr_req`: 1 leaves sleep, 0 enters sleep |
| tx_ready | input | 1 | Serializer accepts the offered byte |
| tx_valid | output | 1 | A byte is offered |
| tx_data | output | 8 | Offered byte |
| tx_dc | output | 1 | 0 for an opcode, 1 for a parameter |
| lcd_rst_n | output | 1 | Active-low hardware reset to the panel |
| done | output | 1 | Bring-up finished |

## Verification
The assertions assume the serializer may hold `tx_ready` low for any number of cycles, and that `start` is a level the block samples only when idle. The stimulus runs the bring-up once with `tx_ready` always high and once under pseudo-random backpressure, and the two byte streams must be identical. A second `start` pulse is injected mid-sequence, and power requests are issued only after `done`, while the block is idle. The bench expects the stream to match what it derives from its own walk of the record list in R4.

// File: rtl/lcd_bringup_seq.sv
module lcd_bringup_seq #(
  parameter int MS_TICKS   = 50000,
  parameter int MAX_PARAMS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pwr_req,
  input  logic       pwr_on,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_dc,
  output logic       lcd_rst_n,
  output logic       done
);
  localparam int TBL_LEN = 45;
  localparam int PW = $clog2(TBL_LEN + 1);
  localparam int CW = $clog2(MAX_PARAMS + 1);
  localparam int TW = $clog2(5 * MS_TICKS);
  localparam logic [TW-1:0] MS_END  = TW'(MS_TICKS - 1);
  localparam logic [TW-1:0] SET_END = TW'(5 * MS_TICKS - 1);
  localparam logic [PW-1:0] LAST    = PW'(TBL_LEN - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RLO, S_RHI, S_LOAD, S_OP, S_PAR, S_SETTLE, S_DISPON, S_PWR
  } state_t;

  state_t        st;
  logic [TW-1:0] tmr;
  logic [PW-1:0] ptr;
  logic [CW-1:0] cnt;
  logic          pwr_sel;

  function automatic logic [7:0] rom_byte(input logic [PW-1:0] i);
    case (i)
      6'd0:  rom_byte = 8'd1;   6'd1:  rom_byte = 8'hC0; 6'd2:  rom_byte = 8'h26;
      6'd3:  rom_byte = 8'd1;   6'd4:  rom_byte = 8'h36; 6'd5:  rom_byte = 8'h28;
      6'd6:  rom_byte = 8'd1;   6'd7:  rom_byte = 8'h3A; 6'd8:  rom_byte = 8'h55;
      6'd9:  rom_byte = 8'd15;  6'd10: rom_byte = 8'hE0;
      6'd11: rom_byte = 8'h0F;  6'd12: rom_byte = 8'h31; 6'd13: rom_byte = 8'h2B;
      6'd14: rom_byte = 8'h0C;  6'd15: rom_byte = 8'h0E; 6'd16: rom_byte = 8'h08;
      6'd17: rom_byte = 8'h4E;  6'd18: rom_byte = 8'hF1; 6'd19: rom_byte = 8'h37;
      6'd20: rom_byte = 8'h07;  6'd21: rom_byte = 8'h10; 6'd22: rom_byte = 8'h03;
      6'd23: rom_byte = 8'h0E;  6'd24: rom_byte = 8'h09; 6'd25: rom_byte = 8'h00;
      6'd26: rom_byte = 8'd15;  6'd27: rom_byte = 8'hE1;
      6'd28: rom_byte = 8'h00;  6'd29: rom_byte = 8'h0E; 6'd30: rom_byte = 8'h14;
      6'd31: rom_byte = 8'h03;  6'd32: rom_byte = 8'h11; 6'd33: rom_byte = 8'h07;
      6'd34: rom_byte = 8'h31;  6'd35: rom_byte = 8'hC1; 6'd36: rom_byte = 8'h48;
      6'd37: rom_byte = 8'h08;  6'd38: rom_byte = 8'h0F; 6'd39: rom_byte = 8'h0C;
      6'd40: rom_byte = 8'h31;  6'd41: rom_byte = 8'h36; 6'd42: rom_byte = 8'h0F;
      6'd43: rom_byte = 8'd0;   6'd44: rom_byte = 8'h11;
      default: rom_byte = 8'h00;
    endcase
  endfunction

  assign tx_valid = (st == S_OP) || (st == S_PAR) || (st == S_DISPON) || (st == S_PWR);
  assign tx_dc    = (st == S_PAR);

  always_comb begin
    case (st)
      S_OP, S_PAR: tx_data = rom_byte(ptr);
      S_DISPON:    tx_data = 8'h29;
      S_PWR:       tx_data = pwr_sel ? 8'h11 : 8'h10;
      default:     tx_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      ptr       <= '0;
      cnt       <= '0;
      pwr_sel   <= 1'b0;
      lcd_rst_n <= 1'b1;
      done      <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            st        <= S_RLO;
            tmr       <= '0;
            ptr       <= '0;
            lcd_rst_n <= 1'b0;
            done      <= 1'b0;
          end else if (pwr_req) begin
            st      <= S_PWR;
            pwr_sel <= pwr_on;
          end
        end
        S_RLO: begin
          if (tmr == MS_END) begin
            st        <= S_RHI;
            tmr       <= '0;
            lcd_rst_n <= 1'b1;
          end else tmr <= tmr + 1'b1;
        end
        S_RHI: begin
          if (tmr == MS_END) st <= S_LOAD;
          else tmr <= tmr + 1'b1;
        end
        S_LOAD: begin
          cnt <= CW'(rom_byte(ptr));
          ptr <= ptr + 1'b1;
          st  <= S_OP;
        end
        S_OP: begin
          if (tx_ready) begin
            ptr <= ptr + 1'b1;
            if (ptr == LAST) begin
              st  <= S_SETTLE;
              tmr <= '0;
            end else if (cnt == '0) st <= S_LOAD;
            else st <= S_PAR;
          end
        end
        S_PAR: begin
          if (tx_ready) begin
            ptr <= ptr + 1'b1;
            cnt <= cnt - 1'b1;
            if (ptr == LAST) begin
              st  <= S_SETTLE;
              tmr <= '0;
            end else if (cnt == CW'(1)) st <= S_LOAD;
          end
        end
        S_SETTLE: begin
          if (tmr == SET_END) st <= S_DISPON;
          else tmr <= tmr + 1'b1;
        end
        S_DISPON: begin
          if (tx_ready) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        S_PWR: if (tx_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module lcd_bringup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_dc,
  input logic       lcd_rst_n,
  input logic       done
);
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_dc));

  a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rst_n |-> !tx_valid);

  a_r7_done_after_dispon: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tx_valid && tx_ready && !tx_dc && tx_data == 8'h29));

  a_r8_pulse_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_rst_n) |-> $past(start));

  a_r7_done_panel_live: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lcd_rst_n);
endmodule

bind lcd_bringup_seq lcd_bringup_seq_chk u_chk (.*);

// File: tb/lcd_bringup_seq_test.sv
module lcd_bringup_seq_test;
  localparam int MS = 8;

  logic clk = 0, rst_n = 0, start = 0, pwr_req = 0, pwr_on = 0, tx_ready = 0;
  logic tx_valid, tx_dc, lcd_rst_n, done;
  logic [7:0] tx_data;

  lcd_bringup_seq #(.MS_TICKS(MS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pwr_req(pwr_req), .pwr_on(pwr_on),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_dc(tx_dc),
    .lcd_rst_n(lcd_rst_n), .done(done));

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0;
  int bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] lb [0:63];
  logic       ld [0:63];
  int         lc [0:63];
  int ln, nc, low_cnt, falls, rise_cyc, first_valid, dispon_valid;
  logic prev_rst = 1;

  logic [7:0] eb [0:63];
  logic       ed [0:63];
  int en;

  function automatic logic [7:0] tbl(int i);
    logic [7:0] t [0:44];
    t = '{8'd1, 8'hC0, 8'h26, 8'd1, 8'h36, 8'h28, 8'd1, 8'h3A, 8'h55,
          8'd15, 8'hE0, 8'h0F, 8'h31, 8'h2B, 8'h0C, 8'h0E, 8'h08, 8'h4E,
          8'hF1, 8'h37, 8'h07, 8'h10, 8'h03, 8'h0E, 8'h09, 8'h00,
          8'd15, 8'hE1, 8'h00, 8'h0E, 8'h14, 8'h03, 8'h11, 8'h07, 8'h31,
          8'hC1, 8'h48, 8'h08, 8'h0F, 8'h0C, 8'h31, 8'h36, 8'h0F,
          8'd0, 8'h11};
    return t[i];
  endfunction

  task automatic build_expected();
    int i = 0;
    en = 0;
    while (i < 45) begin
      int n = tbl(i);
      eb[en] = tbl(i + 1); ed[en] = 1'b0; en++;
      for (int k = 0; k < n; k++) begin
        eb[en] = tbl(i + 2 + k); ed[en] = 1'b1; en++;
      end
      i += n + 2;
    end
    eb[en] = 8'h29; ed[en] = 1'b0; en++;
  endtask

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    ln = 0; low_cnt = 0; falls = 0; rise_cyc = -1; first_valid = -1; dispon_valid = -1;
  endtask

  always begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = (bp_mode == 0) ? 1'b1 : lfsr[0];
    #1;
    nc++;
    if (!lcd_rst_n) low_cnt++;
    if (prev_rst && !lcd_rst_n) falls++;
    if (!prev_rst && lcd_rst_n) rise_cyc = nc;
    prev_rst = lcd_rst_n;
    if (tx_valid && first_valid < 0) first_valid = nc;
    if (tx_valid && tx_data == 8'h29 && !tx_dc && dispon_valid < 0) dispon_valid = nc;
    if (tx_valid && tx_ready && ln < 64) begin
      lb[ln] = tx_data; ld[ln] = tx_dc; lc[ln] = nc; ln++;
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic wait_done();
    int g = 0;
    while (!done && g < 5000) begin @(negedge clk); g++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_bringup(string tag);
    chk({tag, " R3 byte count"}, ln, en);
    for (int i = 0; i < en && i < ln; i++) begin
      chk({tag, " R4 byte"}, lb[i], eb[i]);
      chk({tag, " R3 dc flag"}, ld[i], ed[i]);
    end
    chk({tag, " R2 reset low cycles"}, low_cnt, MS);
    chk({tag, " R8 single reset pulse"}, falls, 1);
    chk({tag, " R2 release to first byte"}, (first_valid - rise_cyc) >= MS, 1);
    chk({tag, " R6 settle gap"}, (ln >= 2) && (dispon_valid - lc[ln-2] >= 5 * MS), 1);
    chk({tag, " R7 done high"}, done, 1);
    chk({tag, " R7 panel out of reset"}, lcd_rst_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    build_expected();
    clear_log();
    nc = 0;
    repeat (4) @(negedge clk);
    chk("R1 reset lcd_rst_n", lcd_rst_n, 1);
    chk("R1 reset tx_valid", tx_valid, 0);
    chk("R1 reset done", done, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle tx_valid", tx_valid, 0);
    chk("R1 idle done", done, 0);

    clear_log();
    pulse(start);
    repeat (30) @(negedge clk);
    pulse(start);
    repeat (60) @(negedge clk);
    pulse(start);
    wait_done();
    check_bringup("run1");

    clear_log();
    pwr_on = 0;
    pulse(pwr_req);
    repeat (6) @(negedge clk);
    chk("R9 sleep-in count", ln, 1);
    chk("R9 sleep-in byte", lb[0], 8'h10);
    chk("R9 sleep-in dc", ld[0], 0);
    chk("R9 done kept", done, 1);
    chk("R9 reset pin kept", lcd_rst_n, 1);

    clear_log();
    pwr_on = 1;
    pulse(pwr_req);
    repeat (6) @(negedge clk);
    chk("R9 sleep-out count", ln, 1);
    chk("R9 sleep-out byte", lb[0], 8'h11);
    chk("R9 sleep-out dc", ld[0], 0);
    chk("R9 done kept", done, 1);

    bp_mode = 1;
    clear_log();
    pulse(start);
    repeat (2) @(negedge clk);
    chk("R7 start clears done", done, 0);
    repeat (40) @(negedge clk);
    pulse(start);
    wait_done();
    check_bringup("run2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule